// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Target

This block sits on the target side of a bus on which one set of pins carries the low address byte first and a data byte afterwards. A strobe from the master marks the address phase. The block keeps the low address byte that the shared lines carried at the close of that phase. It joins this byte with the dedicated high address pins to form a full address, which stays steady for the whole data phase.

From that address and from the active request strobe, the block decides whether the access belongs to it. A memory request is checked against a small memory window. An I/O request is checked against a short run of port numbers. On a read that hits, it drives one byte from an internal register bank onto the shared lines through a separate output and enable pair. On a write that hits, it stores the byte the master drove. The write takes effect when the write strobe returns high. All bus inputs are taken as synchronous to the block clock.

Top module: `mbt_target`

## Requirements
- R1: After reset the held low address byte is zero, every register in the bank is zero, and `bus_oe` stays low until at least one clock edge has sampled `addr_stb` high, whatever the strobes do.
- R2: On every clock edge that samples `addr_stb` high, the held low byte takes the value of `bus_in`. While `addr_stb` is low it keeps its value, so data on `bus_in` does not change the decoded address.
- R3: With `mem_req_n` low and `io_req_n` high, the access hits when the address `{addr_hi, held low byte}` lies in `MEM_BASE` .. `MEM_BASE+MEM_REGS-1`. The address `MEM_BASE+k` selects register k.
- R4: With `io_req_n` low and `mem_req_n` high, the access hits when the held low byte lies in `IO_BASE` .. `IO_BASE+IO_REGS-1`. Port `IO_BASE+k` selects register `MEM_REGS+k`, and `addr_hi` is ignored.
- R5: `bus_oe` is high exactly when an address phase has been seen, `addr_stb` is low, `rd_n` is low and the access hits. `bus_out` then carries the selected register and is zero otherwise.
- R6: A write takes the `bus_in` value sampled on the last clock edge with `wr_n` low. It commits it to the selected register on the first edge that samples `wr_n` high again, and no register changes on an edge that samples `wr_n` low.
- R7: An access that misses leaves `bus_oe` low and all registers unchanged.
- R8: An access with both `mem_req_n` and `io_req_n` low is a miss: no drive and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; bus inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_stb | input | 1 | High during the address phase of the shared lines |
| bus_in | input | 8 | Value seen on the shared address/data lines |
| addr_hi | input | 8 | Dedicated high address byte |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| mem_req_n | input | 1 | Active-low memory request |
| io_req_n | input | 1 | Active-low I/O request |
| bus_out | output | 8 | Byte to drive on the shared lines during a hit read |
| bus_oe | output | 1 | Tri-state enable for the shared lines |

## Verification
On every cycle the assertions check these rules. The enable is never raised during the address phase, without a read strobe, with both request strobes active, or before the first address phase. The held byte follows the shared lines while the address strobe is high and freezes once it falls. The register bank never changes while the write strobe is low. Only the bench's scenarios can show which register a given memory address or port number selects, and the window edges and port-range edges. They also show that the last byte of a long write strobe is the one kept, and that misses leave every register as it was.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
    typedef enum logic [1:0] {
        SPACE_NONE = 2'd0,
        SPACE_MEM  = 2'd1,
        SPACE_IO   = 2'd2
    } space_e;
endpackage

// File: rtl/mbt_addr_hold.sv
module mbt_addr_hold #(
    parameter int LO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            addr_stb,
    input  logic [LO_W-1:0] bus_in,
    output logic [LO_W-1:0] held_lo,
    output logic            seen
);
    typedef struct packed {
        logic [LO_W-1:0] lo;
        logic            seen;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (addr_stb) begin
            h_d.lo   = bus_in;
            h_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign held_lo = h_q.lo;
    assign seen    = h_q.seen;
endmodule

// File: rtl/mbt_decode.sv
module mbt_decode
    import mbt_pkg::*;
#(
    parameter int LO_W     = 8,
    parameter int HI_W     = 8,
    parameter int MEM_BASE = 'h4000,
    parameter int MEM_REGS = 8,
    parameter int IO_BASE  = 'h20,
    parameter int IO_REGS  = 4,
    localparam int ADDR_W  = LO_W + HI_W,
    localparam int NREG    = MEM_REGS + IO_REGS,
    localparam int IDX_W   = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic [HI_W-1:0]  addr_hi,
    input  logic [LO_W-1:0]  held_lo,
    input  logic             mem_req_n,
    input  logic             io_req_n,
    output space_e           space,
    output logic [IDX_W-1:0] idx
);
    logic [ADDR_W-1:0]   full_addr;
    logic [MEM_REGS-1:0] mem_match;
    logic [IO_REGS-1:0]  io_match;

    assign full_addr = {addr_hi, held_lo};

    for (genvar g = 0; g < MEM_REGS; g++) begin : g_mem
        assign mem_match[g] = (full_addr == ADDR_W'(MEM_BASE + g));
    end

    for (genvar g = 0; g < IO_REGS; g++) begin : g_io
        assign io_match[g] = (held_lo == LO_W'(IO_BASE + g));
    end

    always_comb begin
        space = SPACE_NONE;
        idx   = '0;
        if (!mem_req_n && io_req_n && (|mem_match)) begin
            space = SPACE_MEM;
            for (int i = 0; i < MEM_REGS; i++) begin
                if (mem_match[i]) idx = IDX_W'(i);
            end
        end else if (!io_req_n && mem_req_n && (|io_match)) begin
            space = SPACE_IO;
            for (int i = 0; i < IO_REGS; i++) begin
                if (io_match[i]) idx = IDX_W'(MEM_REGS + i);
            end
        end
    end
endmodule

// File: rtl/mbt_regbank.sv
module mbt_regbank #(
    parameter int DW      = 8,
    parameter int NREG    = 12,
    localparam int IDX_W  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_n,
    input  logic [DW-1:0]    bus_in,
    input  logic             hit,
    input  logic [IDX_W-1:0] idx,
    output logic [DW-1:0]    rdata,
    output logic [NREG*DW-1:0] reg_flat
);
    typedef struct packed {
        logic                     wr_prev;
        logic                     pend_hit;
        logic [IDX_W-1:0]         pend_idx;
        logic [DW-1:0]            pend_data;
        logic [NREG-1:0][DW-1:0]  regs;
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.wr_prev = wr_n;
        if (!wr_n) begin
            s_d.pend_hit  = hit;
            s_d.pend_idx  = idx;
            s_d.pend_data = bus_in;
        end
        if (wr_n && !s_q.wr_prev && s_q.pend_hit) begin
            for (int i = 0; i < NREG; i++) begin
                if (s_q.pend_idx == IDX_W'(i)) s_d.regs[i] = s_q.pend_data;
            end
            s_d.pend_hit = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.wr_prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (idx == IDX_W'(i)) rdata = s_q.regs[i];
        end
    end

    assign reg_flat = s_q.regs;
endmodule

// File: rtl/mbt_target.sv
module mbt_target
    import mbt_pkg::*;
#(
    parameter int LO_W     = 8,
    parameter int HI_W     = 8,
    parameter int MEM_BASE = 'h4000,
    parameter int MEM_REGS = 8,
    parameter int IO_BASE  = 'h20,
    parameter int IO_REGS  = 4,
    localparam int NREG    = MEM_REGS + IO_REGS,
    localparam int IDX_W   = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            addr_stb,
    input  logic [LO_W-1:0] bus_in,
    input  logic [HI_W-1:0] addr_hi,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic            mem_req_n,
    input  logic            io_req_n,
    output logic [LO_W-1:0] bus_out,
    output logic            bus_oe
);
    logic [LO_W-1:0]      held_lo;
    logic                 seen;
    space_e               space;
    logic [IDX_W-1:0]     idx;
    logic                 access_ok;
    logic [LO_W-1:0]      rdata;
    logic [NREG*LO_W-1:0] reg_flat;

    mbt_addr_hold #(.LO_W(LO_W)) i_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_stb (addr_stb),
        .bus_in   (bus_in),
        .held_lo  (held_lo),
        .seen     (seen)
    );

    mbt_decode #(
        .LO_W(LO_W), .HI_W(HI_W), .MEM_BASE(MEM_BASE), .MEM_REGS(MEM_REGS),
        .IO_BASE(IO_BASE), .IO_REGS(IO_REGS)
    ) i_dec (
        .addr_hi   (addr_hi),
        .held_lo   (held_lo),
        .mem_req_n (mem_req_n),
        .io_req_n  (io_req_n),
        .space     (space),
        .idx       (idx)
    );

    assign access_ok = seen && !addr_stb && (space != SPACE_NONE);

    mbt_regbank #(.DW(LO_W), .NREG(NREG)) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_n     (wr_n),
        .bus_in   (bus_in),
        .hit      (access_ok),
        .idx      (idx),
        .rdata    (rdata),
        .reg_flat (reg_flat)
    );

    assign bus_oe  = access_ok && !rd_n;
    assign bus_out = bus_oe ? rdata : '0;
endmodule

// File: rtl/mbt_target_chk.sv
module mbt_target_chk #(
    parameter int LO_W   = 8,
    parameter int FLAT_W = 96
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_stb,
    input logic [LO_W-1:0]   bus_in,
    input logic              rd_n,
    input logic              wr_n,
    input logic              mem_req_n,
    input logic              io_req_n,
    input logic              bus_oe,
    input logic [LO_W-1:0]   held_lo,
    input logic [FLAT_W-1:0] reg_flat
);
    logic stb_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stb_seen_q <= 1'b0;
        else if (addr_stb) stb_seen_q <= 1'b1;
    end

    // R1
    no_drive_before_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_seen_q |-> !bus_oe);

    // R5
    drive_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (!addr_stb && !rd_n));

    // R8
    no_drive_dual_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req_n && !io_req_n) |-> !bus_oe);

    // R2
    low_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_stb |=> (held_lo == $past(bus_in)));

    // R2
    low_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_stb |=> $stable(held_lo));

    // R6
    no_commit_during_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |=> $stable(reg_flat));
endmodule

bind mbt_target mbt_target_chk #(.LO_W(LO_W), .FLAT_W(NREG*LO_W)) i_mbt_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_stb  (addr_stb),
    .bus_in    (bus_in),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .mem_req_n (mem_req_n),
    .io_req_n  (io_req_n),
    .bus_oe    (bus_oe),
    .held_lo   (held_lo),
    .reg_flat  (reg_flat)
);

// File: tb/test_mbt_target.sv
`timescale 1ns/1ps
module test_mbt_target;
    localparam int NREG = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_stb = 1'b0;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] addr_hi = 8'h00;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       mem_req_n = 1'b1;
    logic       io_req_n = 1'b1;
    logic [7:0] bus_out;
    logic       bus_oe;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] shadow [NREG];

    always #2.5 clk = ~clk;

    mbt_target i_mbt_target (
        .clk(clk), .rst_n(rst_n), .addr_stb(addr_stb), .bus_in(bus_in),
        .addr_hi(addr_hi), .rd_n(rd_n), .wr_n(wr_n), .mem_req_n(mem_req_n),
        .io_req_n(io_req_n), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got oe/data %h expected %h", tag, act, exp);
        end
    endtask

    task automatic addr_phase(logic [7:0] hi, logic [7:0] lo);
        @(negedge clk);
        addr_stb = 1'b1; bus_in = lo; addr_hi = hi;
        @(negedge clk);
        addr_stb = 1'b0; bus_in = 8'h00;
    endtask

    task automatic bus_write(bit io, logic [7:0] data);
        if (io) io_req_n = 1'b0; else mem_req_n = 1'b0;
        wr_n = 1'b0; bus_in = data;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        mem_req_n = 1'b1; io_req_n = 1'b1; bus_in = 8'h00;
    endtask

    task automatic bus_read(bit io, bit exp_oe, logic [7:0] exp_d, string tag);
        if (io) io_req_n = 1'b0; else mem_req_n = 1'b0;
        rd_n = 1'b0; bus_in = 8'h5A;
        #1;
        check(tag, {bus_oe, bus_out}, {exp_oe, exp_oe ? exp_d : 8'h00});
        @(negedge clk);
        rd_n = 1'b1; mem_req_n = 1'b1; io_req_n = 1'b1; bus_in = 8'h00;
    endtask

    task automatic t_reset;
        #1;
        check("R1 reset enable", {bus_oe, bus_out}, 9'h000);
    endtask

    task automatic t_prelatch;
        // held byte is zero, so 0x4000 would hit without the seen rule
        @(negedge clk);
        addr_hi = 8'h40; mem_req_n = 1'b0; rd_n = 1'b0;
        #1;
        check("R1 no drive before first address phase", {bus_oe, bus_out}, 9'h000);
        @(negedge clk);
        check("R1 no drive before first address phase (2)", {bus_oe, bus_out}, 9'h000);
        mem_req_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic t_mem_rw;
        addr_phase(8'h40, 8'h01);
        bus_read(0, 1, 8'h00, "R1 register reset value");
        addr_phase(8'h40, 8'h00); bus_write(0, 8'hA1); shadow[0] = 8'hA1;
        addr_phase(8'h40, 8'h05); bus_write(0, 8'hB2); shadow[5] = 8'hB2;
        addr_phase(8'h40, 8'h00); bus_read(0, 1, shadow[0], "R3 read window start");
        addr_phase(8'h40, 8'h05); bus_read(0, 1, shadow[5], "R3 read offset 5");
    endtask

    task automatic t_boundary;
        addr_phase(8'h40, 8'h07); bus_write(0, 8'hC3); shadow[7] = 8'hC3;
        addr_phase(8'h40, 8'h07); bus_read(0, 1, shadow[7], "R3 last window byte");
        addr_phase(8'h40, 8'h08); bus_read(0, 0, 8'h00, "R3 one past window");
        addr_phase(8'h3F, 8'hFF); bus_read(0, 0, 8'h00, "R3 one below window");
    endtask

    task automatic t_io;
        addr_phase(8'hAB, 8'h20); bus_write(1, 8'h11); shadow[8] = 8'h11;
        addr_phase(8'h00, 8'h20); bus_read(1, 1, shadow[8], "R4 port ignores high byte");
        addr_phase(8'h12, 8'h23); bus_write(1, 8'h3C); shadow[11] = 8'h3C;
        addr_phase(8'h77, 8'h23); bus_read(1, 1, shadow[11], "R4 last port");
        addr_phase(8'h00, 8'h24); bus_read(1, 0, 8'h00, "R4 past port range");
        addr_phase(8'h40, 8'h20); bus_read(0, 0, 8'h00, "R3 memory request on port number");
    endtask

    task automatic t_follow;
        addr_phase(8'h40, 8'h02); bus_write(0, 8'h5C); shadow[2] = 8'h5C;
        @(negedge clk);
        addr_stb = 1'b1; addr_hi = 8'h40; bus_in = 8'h07;
        @(negedge clk);
        bus_in = 8'h02;
        @(negedge clk);
        addr_stb = 1'b0; bus_in = 8'h07;
        @(negedge clk);
        mem_req_n = 1'b0; rd_n = 1'b0; bus_in = 8'h07;
        #1;
        check("R2 last sampled low byte kept", {bus_oe, bus_out}, {1'b1, shadow[2]});
        @(negedge clk);
        bus_in = 8'h05;
        #1;
        check("R2 data on lines does not move address", {bus_oe, bus_out}, {1'b1, shadow[2]});
        @(negedge clk);
        rd_n = 1'b1; mem_req_n = 1'b1;
    endtask

    task automatic t_read_in_addr_phase;
        @(negedge clk);
        addr_stb = 1'b1; addr_hi = 8'h40; bus_in = 8'h00;
        mem_req_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        #1;
        check("R5 no drive while address strobe high", {bus_oe, bus_out}, 9'h000);
        addr_stb = 1'b0;
        #1;
        check("R5 drive once address strobe low", {bus_oe, bus_out}, {1'b1, shadow[0]});
        @(negedge clk);
        rd_n = 1'b1;
        #1;
        check("R5 no drive without read strobe", {bus_oe, bus_out}, 9'h000);
        mem_req_n = 1'b1;
    endtask

    task automatic t_long_write;
        addr_phase(8'h40, 8'h03);
        mem_req_n = 1'b0; wr_n = 1'b0; bus_in = 8'h11;
        @(negedge clk);
        bus_in = 8'h22;
        @(negedge clk);
        wr_n = 1'b1; bus_in = 8'h99;
        @(negedge clk);
        mem_req_n = 1'b1; bus_in = 8'h00;
        shadow[3] = 8'h22;
        addr_phase(8'h40, 8'h03); bus_read(0, 1, shadow[3], "R6 last byte of write strobe kept");
    endtask

    task automatic t_miss;
        addr_phase(8'h50, 8'h00); bus_write(0, 8'hEE);
        addr_phase(8'h40, 8'h30); bus_write(1, 8'hEF);
        addr_phase(8'h41, 8'h00); bus_read(0, 0, 8'h00, "R7 miss read undriven");
        for (int k = 0; k < 8; k++) begin
            addr_phase(8'h40, 8'(k));
            bus_read(0, 1, shadow[k], $sformatf("R7 memory reg %0d unchanged", k));
        end
        for (int k = 0; k < 4; k++) begin
            addr_phase(8'h00, 8'(8'h20 + k));
            bus_read(1, 1, shadow[8 + k], $sformatf("R7 port reg %0d unchanged", k));
        end
    endtask

    task automatic t_both;
        addr_phase(8'h40, 8'h00);
        mem_req_n = 1'b0; io_req_n = 1'b0; rd_n = 1'b0;
        #1;
        check("R8 both requests no drive", {bus_oe, bus_out}, 9'h000);
        @(negedge clk);
        rd_n = 1'b1; mem_req_n = 1'b1; io_req_n = 1'b1;
        addr_phase(8'h40, 8'h00);
        mem_req_n = 1'b0; io_req_n = 1'b0; wr_n = 1'b0; bus_in = 8'h66;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        mem_req_n = 1'b1; io_req_n = 1'b1;
        addr_phase(8'h40, 8'h00); bus_read(0, 1, shadow[0], "R8 both requests no write");
    endtask

    initial begin
        for (int k = 0; k < NREG; k++) shadow[k] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_prelatch();
        t_mem_rw();
        t_boundary();
        t_io();
        t_follow();
        t_read_in_addr_phase();
        t_long_write();
        t_miss();
        t_both();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule